// File: doc/BRIEF.md
# Refresh Request Scheduler

This block sits on the controller side of a four-bank dynamic memory and decides when a refresh must be sent. A down-counter, reloaded from a cycle count chosen by the operating temperature range, marks each refresh interval; every expiry adds one to a count of refreshes owed. While that count is nonzero the block asks the command sequencer for a refresh. When the sequencer grants it with all banks idle, the count drops by one. A busy flag then blocks every other command for the row-cycle time.

Owed refreshes may pile up to a bounded limit, so the sequencer can postpone refresh around bursts of traffic. At the limit the request is marked urgent and further expiries are absorbed. The block also runs the self-refresh handshake. Entry waits for idle banks and an expired busy window. Exit holds the busy flag for the self-refresh exit time. Refresh carries no address and the command pins are driven elsewhere.

Top module: `refresh_sched`

## Requirements
- R1: While rst_n is low and after its release, ref_req, ref_urgent, busy and sr_active are 0 and debt is 0.
- R2: With hot_grade low, debt rises by one every NORM_CYC cycles while not in self-refresh; the first rise follows the NORM_CYC-th clock edge after reset release.
- R3: ref_req is 1 exactly when debt is nonzero, busy is 0 and sr_active is 0; a ref_grant is accepted only when ref_req and banks_idle are both 1, and otherwise leaves debt and busy unchanged.
- R4: An accepted grant lowers debt by one (an interval expiry in the same cycle offsets it) and raises busy for exactly TRC_CYC cycles starting the next cycle.
- R5: ref_urgent is 1 exactly when debt equals DEBT_MAX; an expiry at that level leaves debt at DEBT_MAX.
- R6: With sr_req 1, banks_idle 1, busy 0 and no accepted grant, sr_active becomes 1 the next cycle, debt clears to 0 and the interval restarts.
- R7: While sr_active is 1, debt stays 0, ref_req stays 0 and grants have no effect.
- R8: When sr_req drops during self-refresh, sr_active returns to 0 the next cycle and busy stays high for exactly TXSR_CYC cycles.
- R9: hot_grade high selects the interval HOT_CYC; the selection is sampled each time the interval counter reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_grade | input | 1 | 1 selects the short refresh interval |
| banks_idle | input | 1 | All four banks are precharged |
| ref_grant | input | 1 | Sequencer issues the refresh this cycle |
| sr_req | input | 1 | Hold high to stay in self-refresh |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Owed count has reached its limit |
| busy | output | 1 | No command may issue |
| sr_active | output | 1 | Self-refresh in progress, clock enable low |
| debt | output | $clog2(DEBT_MAX+1) | Number of refreshes owed |

## Verification
The bench builds the block with NORM_CYC 40, HOT_CYC 10, DEBT_MAX 8, TRC_CYC 5 and TXSR_CYC 7. These short intervals let a run of a hundred cycles drive the owed count to saturation. Switching to the hot rate then shows up in the tick spacing at once. The busy windows of both lengths can also be counted cycle by cycle, and thousands of random grants, idle patterns and self-refresh toggles land on every interaction between expiry, grant and entry.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_SELF = 1'b1
    } sr_mode_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
    parameter int NORM_CYC = 781,
    parameter int HOT_CYC  = 195
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic fast,
    output logic tick
);
    localparam int CW = $clog2(refsched_pkg::max2(NORM_CYC, HOT_CYC));

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ivl_t;

    ivl_t st_d, st_q;
    logic [CW-1:0] reload_val;

    always_comb begin
        reload_val = fast ? CW'(HOT_CYC - 1) : CW'(NORM_CYC - 1);
        st_d = st_q;
        if (restart) begin
            st_d.cnt = reload_val;
        end else if (run) begin
            st_d.cnt = (st_q.cnt == '0) ? reload_val : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: CW'(NORM_CYC - 1)};
        else        st_q <= st_d;
    end

    assign tick = run && (st_q.cnt == '0);
endmodule

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] load_val,
    output logic          busy
);
    typedef struct packed {
        logic [BW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)                st_d.cnt = load_val;
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int NORM_CYC = 781,
    parameter int HOT_CYC  = 195,
    parameter int DEBT_MAX = 8,
    parameter int TRC_CYC  = 6,
    parameter int TXSR_CYC = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hot_grade,
    input  logic                          banks_idle,
    input  logic                          ref_grant,
    input  logic                          sr_req,
    output logic                          ref_req,
    output logic                          ref_urgent,
    output logic                          busy,
    output logic                          sr_active,
    output logic [$clog2(DEBT_MAX+1)-1:0] debt
);
    import refsched_pkg::*;

    localparam int DEBT_W = $clog2(DEBT_MAX + 1);
    localparam int BW     = $clog2(max2(TRC_CYC, TXSR_CYC) + 1);

    typedef struct packed {
        sr_mode_e          mode;
        logic [DEBT_W-1:0] debt;
    } sched_t;

    sched_t st_d, st_q;
    logic tick, accept, enter, leave;
    logic [DEBT_W:0] sum;
    logic [BW-1:0]   busy_val;

    refsched_interval #(.NORM_CYC(NORM_CYC), .HOT_CYC(HOT_CYC)) ivl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.mode == MODE_RUN),
        .restart (enter),
        .fast    (hot_grade),
        .tick    (tick)
    );

    refsched_timer #(.BW(BW)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept || leave),
        .load_val (busy_val),
        .busy     (busy)
    );

    always_comb begin
        ref_req  = (st_q.mode == MODE_RUN) && !busy && (st_q.debt != '0);
        accept   = ref_grant && ref_req && banks_idle;
        enter    = (st_q.mode == MODE_RUN) && sr_req && banks_idle && !busy && !accept;
        leave    = (st_q.mode == MODE_SELF) && !sr_req;
        busy_val = leave ? BW'(TXSR_CYC) : BW'(TRC_CYC);

        sum = {1'b0, st_q.debt} + {{DEBT_W{1'b0}}, tick} - {{DEBT_W{1'b0}}, accept};

        st_d = st_q;
        if (sum > (DEBT_W+1)'(DEBT_MAX)) st_d.debt = DEBT_W'(DEBT_MAX);
        else                            st_d.debt = sum[DEBT_W-1:0];
        if (enter) begin
            st_d.mode = MODE_SELF;
            st_d.debt = '0;
        end else if (leave) begin
            st_d.mode = MODE_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: MODE_RUN, debt: '0};
        else        st_q <= st_d;
    end

    assign debt       = st_q.debt;
    assign ref_urgent = (st_q.debt == DEBT_W'(DEBT_MAX));
    assign sr_active  = (st_q.mode == MODE_SELF);
endmodule

// File: rtl/refresh_sched_sva.sv
module refresh_sched_sva #(
    parameter int DEBT_MAX = 8,
    parameter int DEBT_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              banks_idle,
    input logic              ref_grant,
    input logic              sr_req,
    input logic              ref_req,
    input logic              busy,
    input logic              sr_active,
    input logic [DEBT_W-1:0] debt
);
    // R4: an accepted grant opens the busy window next cycle
    a_r4_busy_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_grant && ref_req && banks_idle) |=> busy);

    // R5: owed count never passes its limit
    a_r5_debt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(debt) <= DEBT_MAX);

    // R2: the owed count grows by at most one per cycle
    a_r2_debt_step: assert property (@(posedge clk) disable iff (!rst_n)
        int'(debt) <= int'($past(debt)) + 1);

    // R6: entry only from idle banks with a pending request
    a_r6_entry_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_active) |-> ($past(banks_idle) && $past(sr_req) && !$past(busy)));

    // R7: no refresh request during self-refresh
    a_r7_quiet_in_self: assert property (@(posedge clk) disable iff (!rst_n)
        sr_active |-> (!ref_req && debt == '0));

    // R8: leaving self-refresh starts the exit window
    a_r8_exit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_active) |-> busy);
endmodule

bind refresh_sched refresh_sched_sva #(
    .DEBT_MAX (DEBT_MAX),
    .DEBT_W   ($clog2(DEBT_MAX+1))
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .ref_grant  (ref_grant),
    .sr_req     (sr_req),
    .ref_req    (ref_req),
    .busy       (busy),
    .sr_active  (sr_active),
    .debt       (debt)
);

// File: tb/refresh_sched_tb_top.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;
    localparam int NORM = 40;
    localparam int HOT  = 10;
    localparam int DMAX = 8;
    localparam int TRC  = 5;
    localparam int TXSR = 7;
    localparam int DW   = $clog2(DMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hot_grade = 1'b0, banks_idle = 1'b0, ref_grant = 1'b0, sr_req = 1'b0;
    logic ref_req, ref_urgent, busy, sr_active;
    logic [DW-1:0] debt;

    int checks = 0, errors = 0;
    bit done = 0;
    int m_cnt, m_debt, m_busy;
    bit m_self;

    always #4 clk = ~clk;

    refresh_sched #(.NORM_CYC(NORM), .HOT_CYC(HOT), .DEBT_MAX(DMAX),
                    .TRC_CYC(TRC), .TXSR_CYC(TXSR)) dut_i (
        .clk(clk), .rst_n(rst_n), .hot_grade(hot_grade), .banks_idle(banks_idle),
        .ref_grant(ref_grant), .sr_req(sr_req), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .busy(busy), .sr_active(sr_active), .debt(debt));

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_req();
        return !m_self && m_busy == 0 && m_debt != 0;
    endfunction

    task automatic cmp_model();
        cmp("R2 debt", int'(debt), m_debt);
        cmp("R3 ref_req", int'(ref_req), int'(exp_req()));
        cmp("R5 ref_urgent", int'(ref_urgent), int'(m_debt == DMAX));
        cmp("R4 busy", int'(busy), int'(m_busy != 0));
        cmp("R6 sr_active", int'(sr_active), int'(m_self));
    endtask

    task automatic step(input bit idle, input bit gnt, input bit sr, input bit hot);
        bit acc, ent, lv, tk;
        int nd, rl;
        banks_idle = idle; ref_grant = gnt; sr_req = sr; hot_grade = hot;
        @(posedge clk);
        acc = gnt && exp_req() && idle;
        ent = !m_self && sr && idle && m_busy == 0 && !acc;
        lv  = m_self && !sr;
        tk  = !m_self && m_cnt == 0;
        rl  = (hot ? HOT : NORM) - 1;
        if (ent) m_cnt = rl;
        else if (!m_self) m_cnt = (m_cnt == 0) ? rl : m_cnt - 1;
        nd = m_debt + int'(tk) - int'(acc);
        if (nd > DMAX) nd = DMAX;
        if (ent) nd = 0;
        m_debt = nd;
        if (acc) m_busy = TRC;
        else if (lv) m_busy = TXSR;
        else if (m_busy > 0) m_busy--;
        if (ent) m_self = 1;
        else if (lv) m_self = 0;
        @(negedge clk);
        cmp_model();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int nb;
        bit r_sr, r_hot;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: values held in reset
        cmp("R1 ref_req", int'(ref_req), 0);
        cmp("R1 busy", int'(busy), 0);
        cmp("R1 sr_active", int'(sr_active), 0);
        cmp("R1 debt", int'(debt), 0);
        rst_n = 1'b1;
        m_cnt = NORM - 1; m_debt = 0; m_busy = 0; m_self = 0;
        cmp("R1 urgent", int'(ref_urgent), 0);

        for (int i = 1; i <= 39; i++) step(1, 0, 0, 0);
        cmp("R2 before first expiry", int'(debt), 0);
        step(1, 0, 0, 1);
        cmp("R2 first expiry", int'(debt), 1);
        for (int i = 41; i <= 50; i++) step(1, 0, 0, 1);
        cmp("R9 hot interval", int'(debt), 2);
        for (int i = 51; i <= 110; i++) step(1, 0, 0, 1);
        cmp("R5 limit reached", int'(debt), DMAX);
        cmp("R5 urgent", int'(ref_urgent), 1);
        for (int i = 111; i <= 120; i++) step(1, 0, 0, 1);
        cmp("R5 saturates", int'(debt), DMAX);
        step(0, 1, 0, 1);
        cmp("R3 grant ignored debt", int'(debt), DMAX);
        cmp("R3 grant ignored busy", int'(busy), 0);
        step(1, 1, 0, 1);
        cmp("R4 grant busy", int'(busy), 1);
        cmp("R4 grant debt", int'(debt), DMAX - 1);
        step(1, 0, 0, 1);
        for (int i = 0; i < 4; i++) step(1, 0, 1, 1);
        cmp("R6 waits for busy", int'(sr_active), 0);
        step(1, 0, 1, 1);
        cmp("R6 entered", int'(sr_active), 1);
        cmp("R6 debt cleared", int'(debt), 0);
        for (int i = 0; i < 30; i++) step(1, 1, 1, 1);
        cmp("R7 no debt in self", int'(debt), 0);
        cmp("R7 no req in self", int'(ref_req), 0);
        step(1, 0, 0, 1);
        cmp("R8 left", int'(sr_active), 0);
        nb = 0;
        while (busy && nb < 50) begin
            nb++;
            step(1, 0, 0, 1);
        end
        cmp("R8 exit window", nb, TXSR);

        r_sr = 0; r_hot = 0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0)  r_sr  = !r_sr;
            if ($urandom_range(0, 199) == 0) r_hot = !r_hot;
            step($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, r_sr, r_hot);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule